// File: doc/BRIEF.md
# Delayed-PC Fetch Sequencer with Precise Interrupts

This block produces the instruction fetch address for a processor with one branch delay slot. Two program counters are kept instead of one: an intermediate PC that absorbs branch and jump targets, and a fetch PC that always trails it by one advance. Because the fetch PC takes the old intermediate PC on every advance, the instruction after a branch is fetched before the target is, which gives delay-slot behaviour without a separate slot register.

The block also resolves interrupts. A vector of thirteen cause lines, indexed 0 to 12, is reduced by a fixed priority (lowest index wins) after six of the lines are gated by enable bits held in an interrupt-enable register. Causes 1 to 4 restart the interrupted instruction. Causes 5 to 12 resume after it, so the block saves a different pair of return addresses for each kind. Cause 0 aborts to the restart address. A return-from-exception request reloads both PCs from the saved pair.

Top module: `dpc_fetch_seq`

## Requirements
- R1: While rst_n is low, the fetch address becomes 0 and the intermediate PC becomes 4, so link_addr reads 8. Both return registers, cause_idx and irq_enable read 0 and int_taken is low.
- R2: On an advance (adv high) with no active cause and no return request, the fetch address takes the previous intermediate PC and the intermediate PC grows by 4.
- R3: On an advance with br_taken high, the intermediate PC becomes its current value plus br_imm sign-extended from 16 bits.
- R4: On an advance with jr_take high and br_taken low, the intermediate PC becomes jr_target. br_taken wins when both are high.
- R5: link_addr always equals the intermediate PC plus 4.
- R6: With adv, rfe_req and every cause line low, the fetch address and the intermediate PC hold.
- R7: When several enabled causes are active, the lowest index is taken and written to cause_idx.
- R8: Causes 6 to 11 are enabled only while irq_enable bit (index minus 6) is 1, and a masked cause changes nothing. Causes 0 to 5 and 12 cannot be masked.
- R9: A taken cause of index 1 to 4 saves the current intermediate PC in ret_ipc and the current fetch address in ret_dpc.
- R10: A taken cause of index 5 to 12 saves, in ret_ipc, the intermediate PC that the advance would have produced (per R2 to R4), and saves the current intermediate PC in ret_dpc.
- R11: A taken cause of index 1 to 12 sets the fetch address to ISR_ADDR and the intermediate PC to ISR_ADDR plus 4. It also clears irq_enable, ignoring sr_we in that cycle, and raises int_taken for exactly one cycle.
- R12: Cause 0 sets the fetch address to 0, the intermediate PC to 4, cause_idx and irq_enable to 0. It leaves both return registers unchanged and keeps int_taken low.
- R13: rfe_req with no taken cause loads the intermediate PC from ret_ipc and the fetch address from ret_dpc, taking precedence over adv.
- R14: sr_we with no taken cause writes sr_wdata into irq_enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Advance both PCs by one instruction |
| br_taken | input | 1 | Relative branch taken on this advance |
| br_imm | input | IMMW | Branch offset, sign-extended |
| jr_take | input | 1 | Absolute jump on this advance |
| jr_target | input | AW | Absolute jump target |
| rfe_req | input | 1 | Return from exception |
| cause_vec | input | 13 | Active interrupt cause lines |
| sr_we | input | 1 | Write the interrupt-enable register |
| sr_wdata | input | 6 | New enables for causes 6 to 11 |
| fetch_addr | output | AW | Instruction fetch address (delayed PC) |
| link_addr | output | AW | Link value, intermediate PC plus 4 |
| ret_ipc | output | AW | Saved intermediate PC |
| ret_dpc | output | AW | Saved fetch address |
| cause_idx | output | 4 | Index of the last taken cause |
| irq_enable | output | 6 | Enables for maskable causes |
| int_taken | output | 1 | One-cycle pulse after an interrupt is taken |

## Verification
The assertions on following and holding the fetch address assume no cause line is active in the antecedent cycle. They treat any raised line as a possible redirect, even a masked one. The return check likewise assumes rfe_req comes with all cause lines low. The stimulus keeps to this by raising causes only in dedicated steps, separate from the return and plain-advance steps. Masked-cause steps are judged only by the bench, at the ports.

// File: rtl/dpc_pkg.sv
// Shared constants and helpers for the delayed-PC fetch sequencer.
// Assumes the thirteen-cause numbering where 1..4 restart and 6..11 maskable.
package dpc_pkg;
    localparam int CAUSE_N  = 13;
    localparam int IDX_W    = 4;
    localparam int MASK_LO  = 6;
    localparam int MASK_N   = 6;
    localparam int RPT_LO   = 1;
    localparam int RPT_HI   = 4;

    typedef logic [IDX_W-1:0] cause_idx_t;

    // True for causes that restart the interrupted instruction.
    function automatic logic is_restart(input cause_idx_t idx);
        return (int'(idx) >= RPT_LO) && (int'(idx) <= RPT_HI);
    endfunction
endpackage

// File: rtl/dpc_cause_resolver.sv
// Gates the maskable cause lines with their enables and picks the lowest
// active index. Assumes cause lines are level signals valid this cycle.
module dpc_cause_resolver
    import dpc_pkg::*;
(
    input  logic [CAUSE_N-1:0] cause_vec,
    input  logic [MASK_N-1:0]  enable,
    output logic               hit,
    output cause_idx_t         idx,
    output logic               restart
);
    logic [CAUSE_N-1:0] live;

    // Per-cause gating: only the maskable window sees an enable bit.
    for (genvar g = 0; g < CAUSE_N; g++) begin : g_gate
        if (g >= MASK_LO && g < MASK_LO + MASK_N) begin : g_mask
            assign live[g] = cause_vec[g] & enable[g - MASK_LO];
        end else begin : g_fixed
            assign live[g] = cause_vec[g];
        end
    end

    // Priority pick, scanning down so the lowest live index is kept.
    always_comb begin
        idx = '0;
        for (int i = CAUSE_N - 1; i >= 0; i--) begin
            if (live[i]) idx = cause_idx_t'(i);
        end
    end

    assign hit     = |live;
    assign restart = is_restart(idx);
endmodule

// File: rtl/dpc_next_pc.sv
// Computes the intermediate PC an advance would produce: relative branch,
// absolute jump, or sequential step. Assumes br_taken beats jr_take.
module dpc_next_pc #(
    parameter int AW   = 32,
    parameter int IMMW = 16
) (
    input  logic [AW-1:0]   mid_pc,
    input  logic            br_taken,
    input  logic [IMMW-1:0] br_imm,
    input  logic            jr_take,
    input  logic [AW-1:0]   jr_target,
    output logic [AW-1:0]   mid_next
);
    localparam int EXT_W = AW - IMMW;

    logic [AW-1:0] offset;
    assign offset = {{EXT_W{br_imm[IMMW-1]}}, br_imm};

    // Target select for the intermediate PC.
    always_comb begin
        if (br_taken)     mid_next = mid_pc + offset;
        else if (jr_take) mid_next = jr_target;
        else              mid_next = mid_pc + AW'(4);
    end
endmodule

// File: rtl/dpc_fetch_seq.sv
// Delayed-PC fetch sequencer. Fetch address trails the intermediate PC by
// one advance; interrupts save a restart or resume pair and vector to a
// fixed routine. Assumes causes are already synchronous to clk.
module dpc_fetch_seq
    import dpc_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          IMMW     = 16,
    parameter int unsigned ISR_ADDR = 32'h0000_0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                br_taken,
    input  logic [IMMW-1:0]     br_imm,
    input  logic                jr_take,
    input  logic [AW-1:0]       jr_target,
    input  logic                rfe_req,
    input  logic [CAUSE_N-1:0]  cause_vec,
    input  logic                sr_we,
    input  logic [MASK_N-1:0]   sr_wdata,
    output logic [AW-1:0]       fetch_addr,
    output logic [AW-1:0]       link_addr,
    output logic [AW-1:0]       ret_ipc,
    output logic [AW-1:0]       ret_dpc,
    output logic [IDX_W-1:0]    cause_idx,
    output logic [MASK_N-1:0]   irq_enable,
    output logic                int_taken
);
    localparam logic [AW-1:0] BOOT_DPC = '0;
    localparam logic [AW-1:0] BOOT_IPC = AW'(4);
    localparam logic [AW-1:0] VEC_DPC  = AW'(ISR_ADDR);
    localparam logic [AW-1:0] VEC_IPC  = AW'(ISR_ADDR) + AW'(4);

    logic [AW-1:0] mid_pc;
    logic [AW-1:0] dly_pc;
    logic [AW-1:0] mid_next;
    logic          irq_hit;
    cause_idx_t    irq_idx;
    logic          irq_restart;
    logic          abort;

    dpc_next_pc #(.AW(AW), .IMMW(IMMW)) u_next (
        .mid_pc    (mid_pc),
        .br_taken  (br_taken),
        .br_imm    (br_imm),
        .jr_take   (jr_take),
        .jr_target (jr_target),
        .mid_next  (mid_next)
    );

    dpc_cause_resolver u_res (
        .cause_vec (cause_vec),
        .enable    (irq_enable),
        .hit       (irq_hit),
        .idx       (irq_idx),
        .restart   (irq_restart)
    );

    assign abort = irq_hit && (irq_idx == '0);

    // PC pair, return pair, cause and enable update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_pc     <= BOOT_DPC;
            mid_pc     <= BOOT_IPC;
            ret_ipc    <= '0;
            ret_dpc    <= '0;
            cause_idx  <= '0;
            irq_enable <= '0;
            int_taken  <= 1'b0;
        end else begin
            int_taken <= 1'b0;
            if (abort) begin
                dly_pc     <= BOOT_DPC;
                mid_pc     <= BOOT_IPC;
                cause_idx  <= '0;
                irq_enable <= '0;
            end else if (irq_hit) begin
                if (irq_restart) begin
                    ret_ipc <= mid_pc;
                    ret_dpc <= dly_pc;
                end else begin
                    ret_ipc <= mid_next;
                    ret_dpc <= mid_pc;
                end
                dly_pc     <= VEC_DPC;
                mid_pc     <= VEC_IPC;
                cause_idx  <= irq_idx;
                irq_enable <= '0;
                int_taken  <= 1'b1;
            end else begin
                if (rfe_req) begin
                    mid_pc <= ret_ipc;
                    dly_pc <= ret_dpc;
                end else if (adv) begin
                    dly_pc <= mid_pc;
                    mid_pc <= mid_next;
                end
                if (sr_we) irq_enable <= sr_wdata;
            end
        end
    end

    assign fetch_addr = dly_pc;
    assign link_addr  = mid_pc + AW'(4);
endmodule

// File: rtl/dpc_fetch_seq_chk.sv
// Temporal checks on the sequencer ports, bound to every instance.
// Assumes reset is held for at least one clock at start.
module dpc_fetch_seq_chk
    import dpc_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int unsigned ISR_ADDR = 32'h0000_0100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               adv,
    input logic               rfe_req,
    input logic [CAUSE_N-1:0] cause_vec,
    input logic [AW-1:0]      fetch_addr,
    input logic [AW-1:0]      link_addr,
    input logic [AW-1:0]      ret_dpc,
    input logic [IDX_W-1:0]   cause_idx,
    input logic [MASK_N-1:0]  irq_enable,
    input logic               int_taken
);
    assert_fetch_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rfe_req && cause_vec == '0) |=> fetch_addr == $past(link_addr) - AW'(4));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !rfe_req && cause_vec == '0) |=> ($stable(fetch_addr) && $stable(link_addr)));

    assert_cause_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_taken |-> (cause_idx != '0 && int'(cause_idx) < CAUSE_N));

    assert_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int_taken |-> (fetch_addr == AW'(ISR_ADDR) && link_addr == AW'(ISR_ADDR) + AW'(8)
                       && irq_enable == '0));

    assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cause_vec[0] |=> (fetch_addr == '0 && link_addr == AW'(8) && !int_taken));

    assert_return_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_req && cause_vec == '0) |=> fetch_addr == $past(ret_dpc));
endmodule

bind dpc_fetch_seq dpc_fetch_seq_chk #(.AW(AW), .ISR_ADDR(ISR_ADDR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .rfe_req    (rfe_req),
    .cause_vec  (cause_vec),
    .fetch_addr (fetch_addr),
    .link_addr  (link_addr),
    .ret_dpc    (ret_dpc),
    .cause_idx  (cause_idx),
    .irq_enable (irq_enable),
    .int_taken  (int_taken)
);

// File: tb/dpc_fetch_seq_tb.sv
`timescale 1ns/1ps
// Sweeps causes, cause pairs, masks, offsets and returns against a
// behavioural model of the two PCs built from the requirements.
module dpc_fetch_seq_tb_top;
    localparam int AW   = 32;
    localparam int IMMW = 16;
    localparam logic [31:0] ISR = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv = 1'b0, br_taken = 1'b0, jr_take = 1'b0, rfe_req = 1'b0, sr_we = 1'b0;
    logic [IMMW-1:0] br_imm = '0;
    logic [AW-1:0] jr_target = '0;
    logic [12:0] cause_vec = '0;
    logic [5:0] sr_wdata = '0;
    logic [AW-1:0] fetch_addr, link_addr, ret_ipc, ret_dpc;
    logic [3:0] cause_idx;
    logic [5:0] irq_enable;
    logic int_taken;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_ipc, m_dpc, m_ripc, m_rdpc;
    logic [3:0]  m_idx;
    logic [5:0]  m_en;
    logic        m_int;

    always #2 clk = ~clk;

    dpc_fetch_seq #(.AW(AW), .IMMW(IMMW), .ISR_ADDR(ISR)) dut_i (
        .clk(clk), .rst_n(rst_n), .adv(adv), .br_taken(br_taken), .br_imm(br_imm),
        .jr_take(jr_take), .jr_target(jr_target), .rfe_req(rfe_req),
        .cause_vec(cause_vec), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .fetch_addr(fetch_addr), .link_addr(link_addr), .ret_ipc(ret_ipc),
        .ret_dpc(ret_dpc), .cause_idx(cause_idx), .irq_enable(irq_enable),
        .int_taken(int_taken)
    );

    task automatic compare(input string tag);
        checks++;
        if (fetch_addr !== m_dpc || link_addr !== m_ipc + 32'd4 || ret_ipc !== m_ripc ||
            ret_dpc !== m_rdpc || cause_idx !== m_idx || irq_enable !== m_en ||
            int_taken !== m_int) begin
            errors++;
            $display("FAIL %s fetch %h/%h link %h/%h rip %h/%h rdp %h/%h idx %0d/%0d en %h/%h int %b/%b",
                tag, fetch_addr, m_dpc, link_addr, m_ipc + 32'd4, ret_ipc, m_ripc,
                ret_dpc, m_rdpc, cause_idx, m_idx, irq_enable, m_en, int_taken, m_int);
        end
    endtask

    // One cycle of stimulus; model updated from the requirements, checked after the edge.
    task automatic step(input string tag, input logic a, input logic b, input logic [15:0] imm,
                        input logic j, input logic [31:0] tgt, input logic r,
                        input logic [12:0] cv, input logic we, input logic [5:0] wd);
        logic [31:0] nx;
        int win;
        adv = a; br_taken = b; br_imm = imm; jr_take = j; jr_target = tgt;
        rfe_req = r; cause_vec = cv; sr_we = we; sr_wdata = wd;
        nx = b ? m_ipc + {{16{imm[15]}}, imm} : (j ? tgt : m_ipc + 32'd4);
        win = -1;
        for (int i = 12; i >= 0; i--)
            if (cv[i] && ((i < 6 || i > 11) || m_en[i-6])) win = i;
        m_int = 1'b0;
        if (win == 0) begin
            m_dpc = 32'd0; m_ipc = 32'd4; m_idx = 4'd0; m_en = '0;
        end else if (win > 0) begin
            if (win <= 4) begin m_ripc = m_ipc; m_rdpc = m_dpc; end
            else begin m_ripc = nx; m_rdpc = m_ipc; end
            m_dpc = ISR; m_ipc = ISR + 32'd4; m_idx = 4'(win); m_en = '0; m_int = 1'b1;
        end else begin
            if (r) begin m_ipc = m_ripc; m_dpc = m_rdpc; end
            else if (a) begin m_dpc = m_ipc; m_ipc = nx; end
            if (we) m_en = wd;
        end
        @(posedge clk); #1;
        compare(tag);
        adv = 0; br_taken = 0; jr_take = 0; rfe_req = 0; cause_vec = '0; sr_we = 0;
    endtask

    task automatic seq(input string tag);
        step(tag, 1, 0, 16'h0, 0, 32'h0, 0, 13'h0, 0, 6'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_ipc = 32'd4; m_dpc = 32'd0; m_ripc = 0; m_rdpc = 0; m_idx = 0; m_en = 0; m_int = 0;
        repeat (3) @(posedge clk);
        #1 compare("R1");
        rst_n = 1'b1;
        // R2 sequential, R5 link on every step
        for (int k = 0; k < 5; k++) seq("R2");
        // R6 idle hold
        for (int k = 0; k < 3; k++) step("R6", 0, 0, 16'h0, 0, 32'h0, 0, 13'h0, 0, 6'h0);
        // R3 offset sweep including negative and extreme values
        foreach (ISR[k]) begin
            logic [15:0] imm;
            imm = 16'(1 << (k % 16)) ^ (k[0] ? 16'hFFFC : 16'h0);
            step("R3", 1, 1, imm, 0, 32'h0, 0, 13'h0, 0, 6'h0);
        end
        step("R3", 1, 1, 16'h8000, 0, 32'h0, 0, 13'h0, 0, 6'h0);
        step("R3", 1, 1, 16'h7FFC, 0, 32'h0, 0, 13'h0, 0, 6'h0);
        // R4 absolute jump, and branch priority over it
        step("R4", 1, 0, 16'h0, 1, 32'h0000_2000, 0, 13'h0, 0, 6'h0);
        step("R4", 1, 1, 16'h0040, 1, 32'h0000_9000, 0, 13'h0, 0, 6'h0);
        // R14 enable write sweep
        for (int v = 0; v < 64; v++) step("R14", 0, 0, 16'h0, 0, 32'h0, 0, 13'h0, 1, 6'(v));
        // R8 masked causes ignored, enabled causes taken
        for (int c = 6; c <= 11; c++) begin
            step("R14", 0, 0, 16'h0, 0, 32'h0, 0, 13'h0, 1, ~(6'(1) << (c-6)));
            step("R8", 1, 0, 16'h0, 0, 32'h0, 0, 13'(1) << c, 0, 6'h0);
            step("R8", 1, 0, 16'h0, 0, 32'h0, 0, 13'h0, 1, 6'(1) << (c-6));
            step("R8", 1, 0, 16'h0, 0, 32'h0, 0, 13'(1) << c, 0, 6'h0);
            step("R13", 1, 0, 16'h0, 0, 32'h0, 1, 13'h0, 0, 6'h0);
        end
        // R9 / R10 each cause with branch inputs; R11 sr_we ignored; R13 return
        for (int c = 1; c <= 12; c++) begin
            step("R14", 0, 0, 16'h0, 0, 32'h0, 0, 13'h0, 1, 6'h3F);
            seq("R2");
            step(c <= 4 ? "R9" : "R10", 1, c[0], 16'(c * 8), ~c[0], 32'(c * 32'h40), 0,
                 13'(1) << c, 1, 6'h2A);
            step("R11", 0, 0, 16'h0, 0, 32'h0, 0, 13'h0, 0, 6'h0);
            step("R13", 1, 0, 16'h0, 0, 32'h0, 1, 13'h0, 0, 6'h0);
            seq("R2");
        end
        // R7 every pair of causes, lower index must win
        for (int i = 1; i <= 12; i++)
            for (int j = i + 1; j <= 12; j++) begin
                step("R14", 0, 0, 16'h0, 0, 32'h0, 0, 13'h0, 1, 6'h3F);
                step("R7", 1, 0, 16'h0, 0, 32'h0, 0, (13'(1) << i) | (13'(1) << j), 0, 6'h0);
            end
        // R12 abort alone and with other causes
        step("R14", 0, 0, 16'h0, 0, 32'h0, 0, 13'h0, 1, 6'h3F);
        step("R12", 1, 1, 16'h0100, 0, 32'h0, 0, 13'h0001, 0, 6'h0);
        for (int k = 0; k < 3; k++) seq("R2");
        step("R12", 1, 0, 16'h0, 0, 32'h0, 1, 13'h1FFF, 0, 6'h0);
        step("R13", 0, 0, 16'h0, 0, 32'h0, 1, 13'h0, 0, 6'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule